// File: doc/BRIEF.md
# Timestamp-Ordered Sparse Pixel Readout

This block collects hits from a matrix of pixels and streams them out grouped by the time at which they happened. A free-running timestamp counter is sent to every pixel at once. When a pixel's hit strobe fires, the pixel copies the current timestamp into its own storage and holds it until its address has been sent out. A pixel that is already holding an unread hit ignores any further strobes.

Readout is driven by a readout timestamp that starts at zero and steps up by one for each completed readout. A start pulse makes the controller look at the whole matrix. In that cycle every column forms the OR of its pixels' matches against the readout timestamp, and the controller registers these column flags. It then scans only the flagged columns, lowest column first and lowest row first within a column. It emits one address word per accepted clock, and then an end-of-timestamp marker word. Hits that arrive while a readout is in progress are stored with the live timestamp and are kept.

Top module: `tsro_readout`

## Requirements
- R1: The timestamp counter is 6 bits wide. It holds 0 during reset, adds one every clock after reset and wraps from 63 to 0. Stamps taken after a wrap are read out like any other.
- R2: A pixel whose strobe is high in a cycle where it holds no hit stores the counter value of that cycle. Pixel (c, r) is strobe bit c*8+r.
- R3: A strobe to a pixel that already holds an unread hit has no effect. Its stored stamp and its single output word stay as they were.
- R4: The controller accepts a start pulse only while idle. The column flags are evaluated in the next cycle, and the first output word appears in the cycle after that. A start pulse during a readout is ignored.
- R5: A data word (valid high, marker low) carries the column index, the row index and the readout timestamp. It is produced only for pixels whose stored stamp equals the readout timestamp.
- R6: Data words come in ascending row order within a column, and columns come in ascending order. Columns whose flag was low at evaluation are skipped for that timestamp.
- R7: A word is accepted when valid and ready are both high. While ready is low the controller does not advance, and the readout timestamp on the output stays the same.
- R8: After the last matching pixel of a timestamp, one marker word is produced (valid and marker high, column and row 0). A timestamp with no matching pixel produces only the marker, one cycle after evaluation.
- R9: The readout timestamp is 0 after reset. It increments by one, modulo 64, in the cycle after the marker is accepted, and the controller then returns to idle with valid low. Otherwise it does not change.
- R10: An accepted pixel's stored hit is cleared. A strobe in the same cycle as the acceptance is ignored, and a strobe in any later cycle is captured.
- R11: A strobe that arrives during a readout is captured with the live timestamp. If it matches the current readout timestamp and lies in a flagged column, it is included in the current readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | 64 | Per-pixel hit strobes, bit c*8+r for column c, row r |
| rd_start_i | input | 1 | Request to read out the current readout timestamp |
| rd_ready_i | input | 1 | Consumer accepts the presented word |
| out_valid_o | output | 1 | A word is presented |
| out_eot_o | output | 1 | The presented word is the end-of-timestamp marker |
| out_col_o | output | 3 | Column index of the hit |
| out_row_o | output | 3 | Row index of the hit |
| out_ts_o | output | 6 | Current readout timestamp |

## Verification
The hardest situation to reach is a stored stamp that only matches after the readout timestamp has moved forward many times. Such a hit sits in the matrix until the readout counter catches up with it, possibly after the hit counter has wrapped. The stimulus reaches it by storing hits early and then running long chains of back-to-back readouts while strobes follow a spread pattern over all pixels. Some of those strobes land on the cycle a pixel is being accepted, and others land in flagged columns during a scan. A behavioural model tracks every pixel's stamp and predicts each output word cycle by cycle, including the cycles where ready is held low.

// File: rtl/tsro_pkg.sv
package tsro_pkg;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_EVAL = 2'd1,
        RD_SCAN = 2'd2
    } rd_state_e;

endpackage

// File: rtl/tsro_ts_gen.sv
module tsro_ts_gen #(
    parameter int TSW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [TSW-1:0] ts_o
);

    typedef struct packed {
        logic [TSW-1:0] cnt;
    } ts_st_t;

    ts_st_t ts_d, ts_q;

    always_comb begin
        ts_d     = ts_q;
        ts_d.cnt = ts_q.cnt + TSW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    assign ts_o = ts_q.cnt;

endmodule

// File: rtl/tsro_first_set.sv
module tsro_first_set #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        found_o = |req_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/tsro_column.sv
module tsro_column #(
    parameter int NROW = 8,
    parameter int TSW  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NROW-1:0] hit_i,
    input  logic [TSW-1:0]  ts_i,
    input  logic [TSW-1:0]  rts_i,
    input  logic [NROW-1:0] clr_i,
    output logic [NROW-1:0] match_o,
    output logic            any_o
);

    typedef struct packed {
        logic [NROW-1:0]          held;
        logic [NROW-1:0][TSW-1:0] stamp;
    } col_st_t;

    col_st_t col_d, col_q;

    always_comb begin
        col_d = col_q;
        for (int r = 0; r < NROW; r++) begin
            if (!col_q.held[r]) begin
                if (hit_i[r]) begin
                    col_d.held[r]  = 1'b1;
                    col_d.stamp[r] = ts_i;
                end
            end else if (clr_i[r]) begin
                col_d.held[r] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    always_comb begin
        for (int r = 0; r < NROW; r++) begin
            match_o[r] = col_q.held[r] && (col_q.stamp[r] == rts_i);
        end
        any_o = |match_o;
    end

endmodule

// File: rtl/tsro_readout.sv
module tsro_readout #(
    parameter int NCOL = 8,
    parameter int NROW = 8,
    parameter int TSW  = 6,
    localparam int CW  = (NCOL > 1) ? $clog2(NCOL) : 1,
    localparam int RW  = (NROW > 1) ? $clog2(NROW) : 1,
    localparam int NPIX = NCOL * NROW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIX-1:0] hit_i,
    input  logic            rd_start_i,
    input  logic            rd_ready_i,
    output logic            out_valid_o,
    output logic            out_eot_o,
    output logic [CW-1:0]   out_col_o,
    output logic [RW-1:0]   out_row_o,
    output logic [TSW-1:0]  out_ts_o
);
    import tsro_pkg::*;

    typedef struct packed {
        rd_state_e       st;
        logic [TSW-1:0]  rts;
        logic [NCOL-1:0] cflag;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TSW-1:0]             ts_live;
    logic [NCOL-1:0][NROW-1:0]  col_match;
    logic [NCOL-1:0][NROW-1:0]  col_clr;
    logic [NCOL-1:0]            col_any;
    logic [NCOL-1:0]            col_active;
    logic                       c_found;
    logic [CW-1:0]              c_idx;
    logic [NROW-1:0]            sel_match;
    logic                       r_found;
    logic [RW-1:0]              r_idx;
    logic                       word_found;
    logic                       accept;

    tsro_ts_gen #(.TSW(TSW)) u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .ts_o  (ts_live)
    );

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        tsro_column #(.NROW(NROW), .TSW(TSW)) u_col (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit_i   (hit_i[c*NROW +: NROW]),
            .ts_i    (ts_live),
            .rts_i   (ctl_q.rts),
            .clr_i   (col_clr[c]),
            .match_o (col_match[c]),
            .any_o   (col_any[c])
        );
    end

    assign col_active = ctl_q.cflag & col_any;

    tsro_first_set #(.N(NCOL)) u_col_pick (
        .req_i   (col_active),
        .found_o (c_found),
        .idx_o   (c_idx)
    );

    assign sel_match = col_match[c_idx];

    tsro_first_set #(.N(NROW)) u_row_pick (
        .req_i   (sel_match),
        .found_o (r_found),
        .idx_o   (r_idx)
    );

    assign word_found = c_found && r_found;

    always_comb begin
        out_valid_o = (ctl_q.st == RD_SCAN);
        out_eot_o   = out_valid_o && !word_found;
        out_col_o   = word_found ? c_idx : '0;
        out_row_o   = word_found ? r_idx : '0;
        out_ts_o    = ctl_q.rts;
        accept      = out_valid_o && rd_ready_i;
    end

    always_comb begin
        for (int c = 0; c < NCOL; c++) begin
            col_clr[c] = '0;
            if (accept && word_found && (c_idx == CW'(c))) begin
                col_clr[c][r_idx] = 1'b1;
            end
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            RD_IDLE: begin
                if (rd_start_i) begin
                    ctl_d.st = RD_EVAL;
                end
            end
            RD_EVAL: begin
                ctl_d.cflag = col_any;
                ctl_d.st    = RD_SCAN;
            end
            RD_SCAN: begin
                if (accept && !word_found) begin
                    ctl_d.rts   = ctl_q.rts + TSW'(1);
                    ctl_d.cflag = '0;
                    ctl_d.st    = RD_IDLE;
                end
            end
            default: begin
                ctl_d.st = RD_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: RD_IDLE, rts: '0, cflag: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/tsro_readout_chk.sv
module tsro_readout_chk #(
    parameter int TSW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rd_ready_i,
    input logic           out_valid_o,
    input logic           out_eot_o,
    input logic [TSW-1:0] out_ts_o
);

    AST_MARKER_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_eot_o |-> out_valid_o); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !rd_ready_i) |=> (out_valid_o && $stable(out_ts_o))); // R7

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_eot_o && rd_ready_i) |=> (out_ts_o == TSW'($past(out_ts_o) + TSW'(1)))); // R9

    AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid_o && out_eot_o && rd_ready_i) |=> $stable(out_ts_o)); // R9

    AST_IDLE_AFTER_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_eot_o && rd_ready_i) |=> !out_valid_o); // R4

endmodule

bind tsro_readout tsro_readout_chk #(.TSW(TSW)) u_chk (.*);

// File: tb/tsro_readout_bench.sv
`timescale 1ns/100ps
module tsro_readout_bench;

    localparam int NC  = 8;
    localparam int NR  = 8;
    localparam int NP  = NC * NR;
    localparam int TSM = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] hit = '0;
    logic          start = 1'b0;
    logic          ready = 1'b0;
    logic          o_valid, o_eot;
    logic [2:0]    o_col, o_row;
    logic [5:0]    o_ts;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R9";

    int m_v [NP];
    int m_s [NP];
    int m_cf [NC];
    int m_ts, m_rts, m_st;
    int cyc = 0;

    always #2.5 clk = ~clk;

    tsro_readout u_tsro_readout (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit),
        .rd_start_i  (start),
        .rd_ready_i  (ready),
        .out_valid_o (o_valid),
        .out_eot_o   (o_eot),
        .out_col_o   (o_col),
        .out_row_o   (o_row),
        .out_ts_o    (o_ts)
    );

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", cur_req, what, act, exp, cyc);
        end
    endtask

    task automatic tick();
        bit fnd;
        int fc, fr, acc;
        #1;
        fnd = 0; fc = 0; fr = 0;
        if (m_st == 2) begin
            for (int c = 0; c < NC; c++) begin
                for (int r = 0; r < NR; r++) begin
                    if (!fnd && m_cf[c] != 0 && m_v[c*NR+r] != 0 && m_s[c*NR+r] == m_rts) begin
                        fnd = 1; fc = c; fr = r;
                    end
                end
            end
        end
        chk("valid (R7)", int'(o_valid), (m_st == 2) ? 1 : 0);
        chk("marker (R8)", int'(o_eot), (m_st == 2 && !fnd) ? 1 : 0);
        chk("column (R6)", int'(o_col), fc);
        chk("row (R5)", int'(o_row), fr);
        chk("timestamp (R9)", int'(o_ts), m_rts);
        acc = (m_st == 2 && ready) ? 1 : 0;
        if (m_st == 1) begin
            for (int c = 0; c < NC; c++) begin
                m_cf[c] = 0;
                for (int r = 0; r < NR; r++) begin
                    if (m_v[c*NR+r] != 0 && m_s[c*NR+r] == m_rts) m_cf[c] = 1;
                end
            end
        end
        for (int p = 0; p < NP; p++) begin
            if (m_v[p] == 0) begin
                if (hit[p]) begin
                    m_v[p] = 1;
                    m_s[p] = m_ts;
                end
            end else if (acc != 0 && fnd && p == fc*NR+fr) begin
                m_v[p] = 0;
            end
        end
        if (m_st == 0) begin
            if (start) m_st = 1;
        end else if (m_st == 1) begin
            m_st = 2;
        end else if (acc != 0 && !fnd) begin
            m_rts = (m_rts + 1) % TSM;
            m_st  = 0;
            for (int c = 0; c < NC; c++) m_cf[c] = 0;
        end
        m_ts = (m_ts + 1) % TSM;
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    function automatic logic [NP-1:0] pattern(int mode, int k);
        logic [NP-1:0] v = '0;
        if (mode != 0) begin
            for (int p = 0; p < NP; p++) begin
                v[p] = (((k * mode) + (p * 11)) % 37) == 0;
            end
        end
        return v;
    endfunction

    // one readout per iteration; rmode 1 throttles ready
    task automatic readouts(int n, bit hold_start, int rmode, int hmode);
        for (int i = 0; i < n; i++) begin
            int guard = 0;
            start = 1'b1;
            ready = 1'b1;
            hit = pattern(hmode, cyc);
            tick();
            start = hold_start;
            while (m_st != 0 && guard < 300) begin
                ready = (rmode != 0) ? ((cyc % 3) != 0) : 1'b1;
                hit = pattern(hmode, cyc);
                tick();
                guard++;
            end
            start = 1'b0;
            hit = '0;
        end
    endtask

    function automatic int pix(int c, int r);
        return c * NR + r;
    endfunction

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_v[p] = 0;
            m_s[p] = 0;
        end
        for (int c = 0; c < NC; c++) m_cf[c] = 0;
        m_ts = 0; m_rts = 0; m_st = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // reset state, counter stays at 0 until release
        cur_req = "R9";
        tick();

        // R2: stamps taken at counter value 1 in several columns and rows
        cur_req = "R2";
        hit = '0;
        hit[pix(3, 5)] = 1'b1;
        hit[pix(3, 1)] = 1'b1;
        hit[pix(0, 7)] = 1'b1;
        hit[pix(6, 2)] = 1'b1;
        tick();
        hit = '0;
        hit[pix(3, 2)] = 1'b1;
        tick();
        hit = '0;

        // R8: timestamp 0 has no hits, marker only
        cur_req = "R8";
        readouts(1, 1'b0, 0, 0);

        // R3: repeated strobe on a held pixel before its readout
        cur_req = "R3";
        hit[pix(3, 5)] = 1'b1;
        hit[pix(6, 2)] = 1'b1;
        tick();
        hit = '0;

        // R5 R6: timestamp 1 words in row then column order
        cur_req = "R6";
        readouts(1, 1'b0, 0, 0);
        cur_req = "R5";
        readouts(1, 1'b0, 0, 0);

        // R7: throttled consumer
        cur_req = "R7";
        for (int c = 0; c < NC; c++) hit[pix(c, (c * 3) % NR)] = 1'b1;
        tick();
        hit = '0;
        readouts(4, 1'b0, 1, 0);

        // R4: start held high through readouts
        cur_req = "R4";
        readouts(3, 1'b1, 0, 0);

        // R11: strobes during readouts
        cur_req = "R11";
        readouts(20, 1'b0, 0, 5);

        // R10: dense strobes, some on acceptance cycles, with stalls
        cur_req = "R10";
        readouts(40, 1'b1, 1, 3);

        // R1: many readouts so both counters wrap
        cur_req = "R1";
        readouts(160, 1'b0, 0, 7);
        readouts(80, 1'b0, 1, 2);

        cur_req = "R9";
        readouts(70, 1'b0, 0, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule